// File: doc/BRIEF.md
# Select-Controlled Arithmetic Logic Unit

A purely combinational ALU of parameterised width (eight bits by default). Arithmetic work is done by one ripple-carry adder. The adder's second operand is not B itself. It is a steered word chosen by two select lines: zero, B, the complement of B, or all ones. This steered word is added to operand A together with a carry-in. Those four choices and the two carry-in values give eight arithmetic operations, and no separate operator is needed for each one.

A bitwise logic section sits beside the adder and shares the same two select lines. A third select line decides which section drives the result. The unit is built from identical one-bit slices that are replicated across the width. A flag stage adds carry-out, signed overflow, negative and zero indicators. A surrounding data path places the block between its register read ports and its write-back multiplexer.

Top module: `sel_alu`

## Requirements
- R1: With sel[2]=0, the adder's second operand is chosen by sel[1:0]: 00 selects 0, 01 selects B, 10 selects ~B and 11 selects all ones. res equals (A + operand + cin) modulo 2^WIDTH.
- R2: The code sel=010 with cin=1 produces the two's-complement difference A-B. The code sel=011 with cin=1 returns A unchanged.
- R3: With sel[2]=0, cout equals bit WIDTH of the full sum A + operand + cin.
- R4: With sel[2]=0, ovf is 1 exactly when the carry into the top bit differs from the carry out of it. This means the two summed operands have the same sign and res has the other sign.
- R5: With sel[2]=1, sel[1:0] picks a bitwise function: 00 gives A AND B, 01 gives A OR B, 10 gives A XOR B and 11 gives NOT A. cin has no effect on any output.
- R6: With sel[2]=1, cout and ovf are both 0.
- R7: zero is 1 exactly when every bit of res is 0, in both sections.
- R8: neg equals the top bit of res, in both sections.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| sel | input | 3 | Operation select: bit 2 picks the section, bits 1:0 pick the function |
| cin | input | 1 | Carry into the least significant adder slice |
| res | output | WIDTH | Result of the selected section |
| cout | output | 1 | Carry out of the top slice; 0 for logic operations |
| ovf | output | 1 | Signed overflow; 0 for logic operations |
| neg | output | 1 | Top bit of the result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The embedded checks are immediate assertions evaluated whenever the combinational outputs settle. They assume that every input is a known 0 or 1 and that the inputs are held steady while they are evaluated. The bench drives every input from a single procedural point at the rising edge and compares the outputs at the falling edge, so no X or mid-change value ever reaches the checks. The sweep runs a four-bit instance through every pairing of A, B, select code and carry-in, including the sign and carry boundaries.

// File: rtl/sel_alu_pkg.sv
package sel_alu_pkg;
  // section select (sel[2])
  localparam logic SEC_ARITH = 1'b0;
  localparam logic SEC_LOGIC = 1'b1;

  // logic functions on sel[1:0]
  typedef enum logic [1:0] {
    LF_AND  = 2'b00,
    LF_OR   = 2'b01,
    LF_XOR  = 2'b10,
    LF_NOTA = 2'b11
  } logic_fn_e;

  // adder second-operand choices on sel[1:0]
  typedef enum logic [1:0] {
    YS_ZERO = 2'b00,
    YS_B    = 2'b01,
    YS_NOTB = 2'b10,
    YS_ONES = 2'b11
  } ysel_e;
endpackage

// File: rtl/sel_alu_slice.sv
// One bit of the ALU: steered-operand gate, full adder, logic cell, section mux.
module sel_alu_slice
  import sel_alu_pkg::*;
(
  input  logic       a_i,
  input  logic       b_i,
  input  logic [1:0] fsel_i,
  input  logic       sec_i,
  input  logic       c_i,
  output logic       c_o,
  output logic       r_o
);
  logic y_bit;
  logic sum_bit;
  logic lg_bit;

  // steered operand: B when fsel[0], ~B when fsel[1]; both -> 1, neither -> 0
  always_comb begin
    y_bit = (b_i & fsel_i[0]) | (~b_i & fsel_i[1]);
  end

  always_comb begin
    sum_bit = a_i ^ y_bit ^ c_i;
    c_o     = (a_i & y_bit) | (c_i & (a_i ^ y_bit));
  end

  always_comb begin
    unique case (logic_fn_e'(fsel_i))
      LF_AND:  lg_bit = a_i & b_i;
      LF_OR:   lg_bit = a_i | b_i;
      LF_XOR:  lg_bit = a_i ^ b_i;
      default: lg_bit = ~a_i;
    endcase
  end

  always_comb begin
    r_o = (sec_i == SEC_LOGIC) ? lg_bit : sum_bit;
  end
endmodule

// File: rtl/sel_alu_flags.sv
// Status generation from the assembled result and the top carries.
module sel_alu_flags
  import sel_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] res_i,
  input  logic             c_msb_in_i,
  input  logic             c_msb_out_i,
  input  logic             sec_i,
  output logic             cout_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o
);
  always_comb begin
    if (sec_i == SEC_LOGIC) begin
      cout_o = 1'b0;
      ovf_o  = 1'b0;
    end else begin
      cout_o = c_msb_out_i;
      ovf_o  = c_msb_in_i ^ c_msb_out_i;
    end
    neg_o  = res_i[WIDTH-1];
    zero_o = ~(|res_i);
  end

  always_comb begin
    if (sec_i == SEC_LOGIC) begin
      assert_logic_no_carry_R6: assert (!cout_o && !ovf_o)
        else $error("logic op raised carry or overflow");
    end
    assert_neg_zero_excl_R8: assert (!(neg_o && zero_o))
      else $error("negative and zero both set");
  end
endmodule

// File: rtl/sel_alu.sv
module sel_alu
  import sel_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       sel,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf,
  output logic             neg,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] res_w;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    sel_alu_slice u_slice (
      .a_i    (opa[i]),
      .b_i    (opb[i]),
      .fsel_i (sel[1:0]),
      .sec_i  (sel[2]),
      .c_i    (carry[i]),
      .c_o    (carry[i+1]),
      .r_o    (res_w[i])
    );
  end

  sel_alu_flags #(.WIDTH(WIDTH)) u_flags (
    .res_i       (res_w),
    .c_msb_in_i  (carry[MSB]),
    .c_msb_out_i (carry[WIDTH]),
    .sec_i       (sel[2]),
    .cout_o      (cout),
    .ovf_o       (ovf),
    .neg_o       (neg),
    .zero_o      (zero)
  );

  assign res = res_w;

  always_comb begin
    // transfer with no increment can never carry or overflow
    if (sel == 3'b000 && !cin) begin
      assert_transfer_quiet_R4: assert (!cout && !ovf && res == opa)
        else $error("plain transfer altered flags or data");
    end
    // A + all-ones + 1 returns A with a carry out
    if (sel == 3'b011 && cin) begin
      assert_dec_inc_identity_R2: assert (res == opa && cout)
        else $error("A-1+1 did not return A");
    end
    // unsigned add wraps exactly when the result drops below A
    if (sel == 3'b001 && !cin) begin
      assert_add_wrap_R3: assert (cout == (res < opa))
        else $error("carry disagrees with wrap");
    end
    if (sel == 3'b111) begin
      assert_not_a_R5: assert ((res ^ opa) == {WIDTH{1'b1}})
        else $error("NOT A mismatch");
    end
    assert_zero_flag_R7: assert (zero == (res == '0))
      else $error("zero flag mismatch");
  end
endmodule

// File: tb/sim_sel_alu.sv
`timescale 1ns/1ps
module sim_sel_alu;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [W-1:0] opa, opb, res;
  logic [2:0]   sel;
  logic         cin, cout, ovf, neg, zero;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  sel_alu #(.WIDTH(W)) u0 (
    .opa(opa), .opb(opb), .sel(sel), .cin(cin),
    .res(res), .cout(cout), .ovf(ovf), .neg(neg), .zero(zero)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s a=%0d b=%0d sel=%0d cin=%0d: got %0d expected %0d",
               req, what, opa, opb, sel, cin, act, exp);
    end
  endtask

  initial begin
    opa = '0; opb = '0; sel = 3'b000; cin = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    vectors++;
    chk("R7", "idle zero", int'(zero), 1);
    chk("R8", "idle neg", int'(neg), 0);
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a <= MASK; a++) begin
          for (int b = 0; b <= MASK; b++) begin
            int y, sum, er, ec, eo;
            @(posedge clk);
            opa <= a[W-1:0]; opb <= b[W-1:0]; sel <= s[2:0]; cin <= c[0];
            @(negedge clk);
            vectors++;
            if (s < 4) begin
              case (s)
                0: y = 0;
                1: y = b;
                2: y = (~b) & MASK;
                default: y = MASK;
              endcase
              sum = a + y + c;
              er  = sum & MASK;
              ec  = (sum >> W) & 1;
              eo  = (((a >> (W-1)) & 1) == ((y >> (W-1)) & 1)) &&
                    (((er >> (W-1)) & 1) != ((a >> (W-1)) & 1)) ? 1 : 0;
              chk("R1", "arith result", int'(res), er);
              if (s == 2 && c == 1) chk("R2", "subtract", int'(res), (a - b) & MASK);
              if (s == 3 && c == 1) chk("R2", "identity", int'(res), a);
              chk("R3", "carry out", int'(cout), ec);
              chk("R4", "overflow", int'(ovf), eo);
            end else begin
              case (s)
                4: er = a & b;
                5: er = a | b;
                6: er = a ^ b;
                default: er = (~a) & MASK;
              endcase
              chk("R5", "logic result", int'(res), er);
              chk("R6", "logic carry", int'(cout), 0);
              chk("R6", "logic overflow", int'(ovf), 0);
            end
            chk("R7", "zero flag", int'(zero), (er == 0) ? 1 : 0);
            chk("R8", "neg flag", int'(neg), (er >> (W-1)) & 1);
          end
        end
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule